// File: doc/BRIEF.md
# Compressed Load/Store Instruction Expander

This block turns a 16-bit compressed instruction into its 32-bit base-ISA equivalent for 32-bit data transfers. It sits in the decode path. Each cycle it takes one halfword and returns either a full-width load or store word, or a flag that marks the halfword as outside its scope or reserved. The block is purely combinational, so a result is valid in the same cycle as its input.

It handles three groups of compressed encodings.

- Word and single-precision float loads that use the stack pointer as their base.
- Word and single-precision float stores that use the stack pointer as their base.
- Word loads and stores whose base and data registers come from the compressed set x8 to x15.

In every group the offset is zero-extended and multiplied by 4. The expander then places that offset in the immediate fields of the 32-bit word. It also rebuilds the full 5-bit register numbers: x2 is inserted for the stack-pointer forms, and 8 is added to each 3-bit register field. A parameter can remove the float forms, in which case their encodings are flagged instead of expanded.

Top module: `c_ldst_expander`

## Requirements
- R1: An input with bits[1:0]=10, bits[15:13]=010 and rd=bits[11:7] not zero expands to an I-type word. That word has opcode 0000011, funct3 010, rs1=2 and the same rd. Its 12-bit immediate is off[7:6]=bits[3:2], off[5]=bit12, off[4:2]=bits[6:4], with all other immediate bits zero.
- R2: An input with bits[1:0]=10, bits[15:13]=010 and rd=0 is reserved. The illegal output is 1 and the expanded word is all zeros.
- R3: An input with bits[1:0]=10 and bits[15:13]=011 expands like R1, but with opcode 0000111. The destination is a float register number, so rd=0 is accepted.
- R4: An input with bits[1:0]=10 and bits[15:13]=110 expands to an S-type word. That word has opcode 0100011, funct3 010, rs1=2 and rs2=bits[6:2]. The offset is off[5:2]=bits[12:9] and off[7:6]=bits[8:7]. imm[11:5] goes to output bits[31:25] and imm[4:0] goes to output bits[11:7].
- R5: An input with bits[1:0]=10 and bits[15:13]=111 expands like R4, but with opcode 0100111.
- R6: An input with bits[1:0]=00 and bits[15:13]=010 expands to an I-type word with opcode 0000011 and funct3 010. The base register is rs1 from bits[9:7] and the destination is rd from bits[4:2]. The offset is off[5:3]=bits[12:10], off[2]=bit6 and off[6]=bit5.
- R7: An input with bits[1:0]=00 and bits[15:13]=110 expands to an S-type word with opcode 0100011. It uses the same base field and offset layout as R6, and takes rs2 from bits[4:2].
- R8: A 3-bit compressed register field r becomes register number 8+r in the expanded word.
- R9: Offsets are never sign-extended. When every offset bit of the input is set, output immediate bits [11:8] stay zero.
- R10: Every input not covered by R1 and R3 to R7 drives illegal to 1 and the expanded word to zero. This includes the all-zero halfword and the compressed float register forms with bits[1:0]=00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| c_instr | input | 16 | Compressed instruction halfword |
| x_instr | output | 32 | Expanded 32-bit instruction, zero when flagged |
| illegal | output | 1 | High for reserved or unsupported encodings |

## Verification
The block holds no state, so a mis-routed bit-field or a wrong opcode selection shows on x_instr in the same evaluation as the halfword that triggers it. Nothing is deferred to a later cycle. The bench applies every one of the 65536 halfwords and compares each result with an arithmetic model. Because the sweep is complete, a swapped offset bit, a wrong register bias, or a missing reserved-case filter is exposed by at least one input in every group. Fixed inputs with all offset bits set guard the zero-extension boundary.

// File: rtl/cldst_pkg.sv
// Shared constants and word builders for the compressed load/store expander.
// Assumes a 32-bit base instruction format and 16-bit compressed inputs.
package cldst_pkg;
    localparam int CW = 16;
    localparam int IW = 32;
    localparam int RW = 5;
    localparam int IMMW = 12;

    typedef logic [6:0] opc_t;

    localparam opc_t OPC_LOAD   = 7'b0000011;
    localparam opc_t OPC_STORE  = 7'b0100011;
    localparam opc_t OPC_FLOAD  = 7'b0000111;
    localparam opc_t OPC_FSTORE = 7'b0100111;

    localparam logic [2:0] F3_WORD = 3'b010;

    localparam logic [1:0] QUAD_MEM = 2'b00;
    localparam logic [1:0] QUAD_SP  = 2'b10;

    localparam logic [2:0] CF_LDSP  = 3'b010;
    localparam logic [2:0] CF_FLDSP = 3'b011;
    localparam logic [2:0] CF_STSP  = 3'b110;
    localparam logic [2:0] CF_FSTSP = 3'b111;
    localparam logic [2:0] CF_LDREG = 3'b010;
    localparam logic [2:0] CF_STREG = 3'b110;

    localparam logic [RW-1:0] SP_NUM = 5'd2;

    // One expansion path: whether it claims the encoding, whether the result is usable, and the word.
    typedef struct packed {
        logic          hit;
        logic          ok;
        logic [IW-1:0] word;
    } xres_t;

    // Assemble an I-type load word.
    function automatic logic [IW-1:0] mk_load(logic [IMMW-1:0] imm, logic [RW-1:0] rs1,
                                              logic [RW-1:0] rd, opc_t op);
        return {imm, rs1, F3_WORD, rd, op};
    endfunction

    // Assemble an S-type store word with the split immediate.
    function automatic logic [IW-1:0] mk_store(logic [IMMW-1:0] imm, logic [RW-1:0] rs2,
                                               logic [RW-1:0] rs1, opc_t op);
        return {imm[11:5], rs2, rs1, F3_WORD, imm[4:0], op};
    endfunction

    // Widen a 3-bit compressed register field into the x8..x15 window.
    function automatic logic [RW-1:0] widen_reg(logic [2:0] r);
        return {2'b01, r};
    endfunction
endpackage

// File: rtl/sp_load_xpand.sv
// Expands stack-pointer-based word and float-word loads (CI layout).
// Assumes the caller selects among paths via the hit/ok fields; purely combinational.
module sp_load_xpand
    import cldst_pkg::*;
#(
    parameter bit EN_FLOAT = 1'b1
) (
    input  logic [CW-1:0] c_in,
    output xres_t         res
);
    logic            int_sel;
    logic            flt_sel;
    logic [IMMW-1:0] off;
    logic [RW-1:0]   rd;

    // Recognise the integer form from the quadrant and function bits.
    assign int_sel = (c_in[1:0] == QUAD_SP) && (c_in[15:13] == CF_LDSP);

    // The float form exists only when the parameter enables it.
    generate
        if (EN_FLOAT) begin : g_flt
            assign flt_sel = (c_in[1:0] == QUAD_SP) && (c_in[15:13] == CF_FLDSP);
        end else begin : g_noflt
            assign flt_sel = 1'b0;
        end
    endgenerate

    // Gather the scattered offset bits, zero-extended and scaled by 4.
    always_comb begin
        off = {4'b0000, c_in[3:2], c_in[12], c_in[6:4], 2'b00};
        rd  = c_in[11:7];
    end

    // Form the result; the integer form with rd=x0 is reserved.
    always_comb begin
        res.hit  = int_sel | flt_sel;
        res.ok   = flt_sel | (int_sel && (rd != '0));
        res.word = '0;
        if (res.ok) begin
            res.word = mk_load(off, SP_NUM, rd, flt_sel ? OPC_FLOAD : OPC_LOAD);
        end
    end

    // Check the base, the zero-extension and the reserved case on each result.
    always_comb begin
        if (res.ok) begin
            // R1
            spload_base_chk: assert (res.word[19:15] == SP_NUM && res.word[14:12] == F3_WORD);
            // R9
            spload_zext_chk: assert (res.word[31:28] == 4'h0);
            // R2
            spload_rd0_chk: assert (res.word[11:7] != '0 || res.word[6:0] == OPC_FLOAD);
        end
    end
endmodule

// File: rtl/sp_store_xpand.sv
// Expands stack-pointer-based word and float-word stores (CSS layout).
// Assumes every source register number is valid, including x0; purely combinational.
module sp_store_xpand
    import cldst_pkg::*;
#(
    parameter bit EN_FLOAT = 1'b1
) (
    input  logic [CW-1:0] c_in,
    output xres_t         res
);
    logic            int_sel;
    logic            flt_sel;
    logic [IMMW-1:0] off;
    logic [RW-1:0]   rs2;

    // Recognise the integer store form.
    assign int_sel = (c_in[1:0] == QUAD_SP) && (c_in[15:13] == CF_STSP);

    // The float store form exists only when the parameter enables it.
    generate
        if (EN_FLOAT) begin : g_flt
            assign flt_sel = (c_in[1:0] == QUAD_SP) && (c_in[15:13] == CF_FSTSP);
        end else begin : g_noflt
            assign flt_sel = 1'b0;
        end
    endgenerate

    // Gather the offset, zero-extended and scaled by 4, plus the data register.
    always_comb begin
        off = {4'b0000, c_in[8:7], c_in[12:9], 2'b00};
        rs2 = c_in[6:2];
    end

    // Form the store word when this path claims the encoding.
    always_comb begin
        res.hit  = int_sel | flt_sel;
        res.ok   = res.hit;
        res.word = '0;
        if (res.ok) begin
            res.word = mk_store(off, rs2, SP_NUM, flt_sel ? OPC_FSTORE : OPC_STORE);
        end
    end

    // Check the base register and that the upper immediate stays zero.
    always_comb begin
        if (res.ok) begin
            // R4
            spstore_base_chk: assert (res.word[19:15] == SP_NUM && res.word[8:7] == 2'b00);
            // R9
            spstore_zext_chk: assert (res.word[31:28] == 4'h0);
        end
    end
endmodule

// File: rtl/reg_ldst_xpand.sv
// Expands register-based word loads and stores (CL/CS layouts, 3-bit register fields).
// Assumes compressed register fields address x8..x15 only; purely combinational.
module reg_ldst_xpand
    import cldst_pkg::*;
(
    input  logic [CW-1:0] c_in,
    output xres_t         res
);
    logic            ld_sel;
    logic            st_sel;
    logic [IMMW-1:0] off;
    logic [RW-1:0]   base_r;
    logic [RW-1:0]   data_r;

    // Recognise the load and store forms in the memory quadrant.
    always_comb begin
        ld_sel = (c_in[1:0] == QUAD_MEM) && (c_in[15:13] == CF_LDREG);
        st_sel = (c_in[1:0] == QUAD_MEM) && (c_in[15:13] == CF_STREG);
    end

    // Gather the offset and widen both register fields.
    always_comb begin
        off    = {5'b00000, c_in[5], c_in[12:10], c_in[6], 2'b00};
        base_r = widen_reg(c_in[9:7]);
        data_r = widen_reg(c_in[4:2]);
    end

    // Form the load or store word.
    always_comb begin
        res.hit  = ld_sel | st_sel;
        res.ok   = res.hit;
        res.word = '0;
        if (ld_sel) begin
            res.word = mk_load(off, base_r, data_r, OPC_LOAD);
        end else if (st_sel) begin
            res.word = mk_store(off, data_r, base_r, OPC_STORE);
        end
    end

    // Check the register window and the zero-extended offset.
    always_comb begin
        if (res.ok) begin
            // R8
            regldst_window_chk: assert (res.word[19:18] == 2'b01);
            // R9
            regldst_zext_chk: assert (res.word[31:27] == 5'b00000);
        end
    end
endmodule

// File: rtl/c_ldst_expander.sv
// Top of the compressed load/store expander: runs three expansion paths in parallel
// and selects the one that claims the input. Assumes at most one path claims any
// encoding; flagged inputs produce an all-zero word. Purely combinational, no reset.
module c_ldst_expander
    import cldst_pkg::*;
#(
    parameter bit EN_FLOAT = 1'b1
) (
    input  logic [15:0] c_instr,
    output logic [31:0] x_instr,
    output logic        illegal
);
    localparam int NPATH = 3;

    xres_t             path_res [NPATH];
    logic [NPATH-1:0]  hits;
    logic [NPATH-1:0]  oks;
    logic [IW-1:0]     merged;

    sp_load_xpand #(.EN_FLOAT(EN_FLOAT)) u_spld (
        .c_in (c_instr),
        .res  (path_res[0])
    );

    sp_store_xpand #(.EN_FLOAT(EN_FLOAT)) u_spst (
        .c_in (c_instr),
        .res  (path_res[1])
    );

    reg_ldst_xpand u_regls (
        .c_in (c_instr),
        .res  (path_res[2])
    );

    // OR the path words together; only a usable path contributes a nonzero word.
    always_comb begin
        merged = '0;
        for (int k = 0; k < NPATH; k++) begin
            hits[k] = path_res[k].hit;
            oks[k]  = path_res[k].ok;
            merged  = merged | path_res[k].word;
        end
    end

    // Drive the flag and the output word.
    always_comb begin
        illegal = ~|oks;
        x_instr = illegal ? '0 : merged;
    end

    // Check the cross-path relations seen at the ports.
    always_comb begin
        // R10
        path_excl_chk: assert ($onehot0(hits));
        // R10
        flag_zero_chk: assert (!illegal || x_instr == '0);
        // R1
        legal_opc_chk: assert (illegal || x_instr[6:0] == OPC_LOAD || x_instr[6:0] == OPC_STORE
                               || x_instr[6:0] == OPC_FLOAD || x_instr[6:0] == OPC_FSTORE);
        // R8
        legal_base_chk: assert (illegal || x_instr[19:15] == SP_NUM || x_instr[19:18] == 2'b01);
    end
endmodule

// File: tb/c_ldst_expander_test.sv
`timescale 1ns/1ps
module c_ldst_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] c_instr = 16'h0000;
    logic [31:0] x_instr;
    logic        illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    c_ldst_expander uut (
        .c_instr (c_instr),
        .x_instr (x_instr),
        .illegal (illegal)
    );

    // Arithmetic model of the expected expansion and the tag of the requirement involved.
    task automatic model(input int c, output longint w, output bit ill, output string tag);
        int q, f3, off, rd, rs1, rs2;
        q = c % 4;
        f3 = (c / 8192) % 8;
        w = 0;
        ill = 1'b1;
        tag = "R10";
        if (q == 2 && (f3 == 2 || f3 == 3)) begin
            rd  = (c / 128) % 32;
            off = ((c / 4096) % 2) * 32 + ((c / 16) % 8) * 4 + ((c / 4) % 4) * 64;
            if (f3 == 2 && rd == 0) begin
                tag = "R2";
            end else begin
                ill = 1'b0;
                tag = (f3 == 2) ? "R1 R9" : "R3 R9";
                w = longint'(off) * 1048576 + 2 * 32768 + 2 * 4096 + rd * 128 + ((f3 == 2) ? 3 : 7);
            end
        end else if (q == 2 && (f3 == 6 || f3 == 7)) begin
            rs2 = (c / 4) % 32;
            off = ((c / 512) % 16) * 4 + ((c / 128) % 4) * 64;
            ill = 1'b0;
            tag = (f3 == 6) ? "R4 R9" : "R5 R9";
            w = longint'(off / 32) * 33554432 + rs2 * 1048576 + 2 * 32768 + 2 * 4096
                + (off % 32) * 128 + ((f3 == 6) ? 35 : 39);
        end else if (q == 0 && (f3 == 2 || f3 == 6)) begin
            off = ((c / 1024) % 8) * 8 + ((c / 64) % 2) * 4 + ((c / 32) % 2) * 64;
            rs1 = 8 + (c / 128) % 8;
            rd  = 8 + (c / 4) % 8;
            ill = 1'b0;
            if (f3 == 2) begin
                tag = "R6 R8";
                w = longint'(off) * 1048576 + rs1 * 32768 + 2 * 4096 + rd * 128 + 3;
            end else begin
                tag = "R7 R8";
                w = longint'(off / 32) * 33554432 + rd * 1048576 + rs1 * 32768 + 2 * 4096
                    + (off % 32) * 128 + 35;
            end
        end
    endtask

    // Compare the ports against the model for the input currently applied.
    task automatic check_now(input string extra);
        longint w;
        bit     ill;
        string  tag;
        model(int'(c_instr), w, ill, tag);
        n_chk++;
        if (illegal !== ill || x_instr !== w[31:0]) begin
            n_err++;
            $display("FAIL %s%s c=%h got ill=%b w=%h exp ill=%b w=%h",
                     tag, extra, c_instr, illegal, x_instr, ill, w[31:0]);
        end
    endtask

    // Zero-extension boundary: upper immediate bits must stay clear (R9).
    task automatic check_r9_upper(input logic [15:0] c);
        @(negedge clk);
        c_instr = c;
        #1;
        check_now(" R9 boundary");
        n_chk++;
        if (x_instr[31:28] !== 4'h0 || illegal !== 1'b0) begin
            n_err++;
            $display("FAIL R9 c=%h got upper=%h ill=%b exp upper=0 ill=0", c, x_instr[31:28], illegal);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state check: the all-zero halfword is flagged with a zero word (R10).
        @(negedge clk);
        #1;
        check_now(" initial");
        // All-ones offsets on each form (R9).
        check_r9_upper(16'h5FFE);
        check_r9_upper(16'h7FFE);
        check_r9_upper(16'hDFFE);
        check_r9_upper(16'hFFFE);
        check_r9_upper(16'h5FFC);
        check_r9_upper(16'hDFFC);
        // Exhaustive sweep over every halfword (R1 to R10).
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            c_instr = i[15:0];
            #1;
            check_now("");
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired got running exp finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule